// File: doc/BRIEF.md
# Split-Access CSR Bridge with Window Register Bank

This block lets a master with a 32-bit data path read and write a bank of 64-bit control registers. Each 64-bit register takes two 32-bit accesses. Address bit 2 selects the half. A single 32-bit holding latch carries the other half between the two accesses.

A write to the lower half only parks its data in the latch. A write to the upper half joins its data with the latch and commits the full 64-bit word to the addressed register in one step. A read of the lower half returns the low word and loads the latch with the high word. A read of the upper half returns the latch and touches no register, so the two halves of a read always come from one snapshot.

The register bank behind the bridge holds a set of address windows. Each window has a base register, a mask register and a translated-base register. There is also one control register in which only some bits can be written. Each committed write is shown on a commit port, so neighbouring logic can follow changes to the bank. The address translation that these windows describe is done elsewhere.

Top module: `csb_split_bridge`

## Requirements
- R1: A write with address bit 2 clear loads the latch with the write data and nothing else. No commit is reported, and the addressed register keeps its value.
- R2: A write with address bit 2 set commits the 64-bit value {write data, latch}. The target is the offset with bits 2:0 cleared. One cycle after the request, commit_valid pulses for one cycle and commit_addr and commit_data show the target and the value.
- R3: A read with address bit 2 clear returns bits 31:0 of the addressed register. In the same step it loads the latch with bits 63:32 of that register.
- R4: A read with address bit 2 set returns the latch contents. It leaves the latch and every register unchanged, whichever register the address names.
- R5: Window w has a base register at offset 0x000 + 0x40·w and a mask register at 0x100 + 0x40·w. Each register stores bits 31:0 of the committed value and reads back with zero in bits 63:32.
- R6: The translated-base register of window w sits at offset 0x200 + 0x40·w. It stores bits 41:10 of the committed value and reads back that field shifted left by 10, so bits 9:0 and 63:42 read as zero.
- R7: A commit to the control register at offset 0x300 changes only the bits set in the mask 0x0000_001C_FF0F_C7FF. Every other bit keeps its reset value of zero.
- R8: An offset not listed above reads as zero and ignores writes. A lower-half read of such an offset loads the latch with zero.
- R9: After reset the latch, every register, rsp_rdata, commit_addr and commit_data are zero. rsp_valid and commit_valid are low.
- R10: rsp_valid pulses, and rsp_rdata is valid, exactly one cycle after each read request. No write produces rsp_valid.
- R11: Reads and writes share the one latch. An upper-half write that follows a lower-half read commits the high word that the read captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset; bit 2 picks the half, bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| commit_valid | output | 1 | A 64-bit commit happened at the last edge |
| commit_addr | output | ADDR_W (12) | Offset of the committed register (bits 2:0 zero) |
| commit_data | output | 64 | Committed 64-bit value |

## Verification
Every result of the bridge is registered once. A request presented before a rising edge therefore shows its effect at that edge: read data, latch contents, the commit pulse and the new register value. The bench drives each request on a falling edge and holds it for exactly one clock. It samples rsp_rdata, rsp_valid and the commit port on the next falling edge, which is the single cycle in which the pulses are high. Effects on stored state, such as a register that must not change or bits that must stay clear, are read back afterwards through ordinary lower- and upper-half reads.

// File: rtl/csb_pkg.sv
package csb_pkg;

    // Which register group an offset selects.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE,
        SEL_MASK,
        SEL_XLAT,
        SEL_CTRL
    } csb_sel_e;

    // Decoded target: group and window number.
    typedef struct packed {
        csb_sel_e   kind;
        logic [7:0] win;
    } csb_dec_t;

endpackage

// File: rtl/csb_addr_decode.sv
module csb_addr_decode
    import csb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NWIN      = 4,
    parameter int STRIDE_LG = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output csb_dec_t          dec
);
    localparam int SLOT_W = ADDR_W - STRIDE_LG;
    localparam int SUB_W  = STRIDE_LG - 3;

    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;
    logic [2:0]        unused_lo;
    int                slot_i;

    assign slot      = addr[ADDR_W-1:STRIDE_LG];
    assign sub       = addr[STRIDE_LG-1:3];
    assign unused_lo = addr[2:0];
    assign slot_i    = int'(slot);

    // Slots 0..NWIN-1 are base, then mask, then translated base, then control.
    always_comb begin
        dec.kind = SEL_NONE;
        dec.win  = '0;
        if (sub == '0) begin
            if (slot_i < NWIN) begin
                dec.kind = SEL_BASE;
                dec.win  = 8'(slot_i);
            end else if (slot_i < 2 * NWIN) begin
                dec.kind = SEL_MASK;
                dec.win  = 8'(slot_i - NWIN);
            end else if (slot_i < 3 * NWIN) begin
                dec.kind = SEL_XLAT;
                dec.win  = 8'(slot_i - 2 * NWIN);
            end else if (slot_i == 3 * NWIN) begin
                dec.kind = SEL_CTRL;
            end
        end
    end

endmodule

// File: rtl/csb_window_bank.sv
module csb_window_bank
    import csb_pkg::*;
#(
    parameter int NWIN       = 4,
    parameter int WIN_W      = 32,
    parameter int XLAT_SHIFT = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  csb_dec_t    dec,
    input  logic [63:0] wdata,
    output logic [63:0] rdata
);
    typedef struct packed {
        logic [WIN_W-1:0] base;
        logic [WIN_W-1:0] mask;
        logic [WIN_W-1:0] xlat;
    } win_t;

    logic [NWIN-1:0][63:0] contrib;
    logic [63:0]           unused_wd;

    assign unused_wd = wdata;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        win_t win_d;
        win_t win_q;
        logic hit;

        assign hit = (dec.win == 8'(w));

        always_comb begin
            win_d = win_q;
            if (wr_en && hit) begin
                case (dec.kind)
                    SEL_BASE: win_d.base = wdata[WIN_W-1:0];
                    SEL_MASK: win_d.mask = wdata[WIN_W-1:0];
                    SEL_XLAT: win_d.xlat = wdata[XLAT_SHIFT +: WIN_W];
                    default:  win_d = win_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) win_q <= '0;
            else        win_q <= win_d;
        end

        always_comb begin
            contrib[w] = '0;
            if (hit) begin
                case (dec.kind)
                    SEL_BASE: contrib[w] = 64'(win_q.base);
                    SEL_MASK: contrib[w] = 64'(win_q.mask);
                    SEL_XLAT: contrib[w] = 64'(win_q.xlat) << XLAT_SHIFT;
                    default:  contrib[w] = '0;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NWIN; w++) rdata = rdata | contrib[w];
    end

endmodule

// File: rtl/csb_ctrl_reg.sv
module csb_ctrl_reg #(
    parameter logic [63:0] CTRL_MASK = 64'h0000_001C_FF0F_C7FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [63:0] wdata,
    output logic [63:0] rdata
);
    logic [63:0] ctrl_d;
    logic [63:0] ctrl_q;

    // Bits outside the mask are carried over from the stored value.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) ctrl_d = (ctrl_q & ~CTRL_MASK) | (wdata & CTRL_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign rdata = ctrl_q;

endmodule

// File: rtl/csb_split_bridge.sv
module csb_split_bridge
    import csb_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NWIN       = 4,
    parameter int          WIN_W      = 32,
    parameter int          XLAT_SHIFT = 10,
    parameter int          STRIDE_LG  = 6,
    parameter logic [63:0] CTRL_MASK  = 64'h0000_001C_FF0F_C7FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [63:0]       commit_data
);
    typedef struct packed {
        logic [31:0]       latch;
        logic              rsp_valid;
        logic [31:0]       rsp_data;
        logic              cmt_valid;
        logic [ADDR_W-1:0] cmt_addr;
        logic [63:0]       cmt_data;
    } state_t;

    state_t      q;
    state_t      d;
    csb_dec_t    dec;
    logic        upper;
    logic        wr_lo, wr_hi, rd_lo, rd_hi;
    logic [63:0] wide_wdata;
    logic [63:0] bank_rdata;
    logic [63:0] ctrl_rdata;
    logic [63:0] sel_rdata;
    logic        bank_wr, ctrl_wr;

    assign upper = req_addr[2];
    assign wr_lo = req_valid &&  req_write && !upper;
    assign wr_hi = req_valid &&  req_write &&  upper;
    assign rd_lo = req_valid && !req_write && !upper;
    assign rd_hi = req_valid && !req_write &&  upper;

    assign wide_wdata = {req_wdata, q.latch};
    assign bank_wr    = wr_hi && (dec.kind inside {SEL_BASE, SEL_MASK, SEL_XLAT});
    assign ctrl_wr    = wr_hi && (dec.kind == SEL_CTRL);

    csb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NWIN     (NWIN),
        .STRIDE_LG(STRIDE_LG)
    ) u_dec (
        .addr(req_addr),
        .dec (dec)
    );

    csb_window_bank #(
        .NWIN      (NWIN),
        .WIN_W     (WIN_W),
        .XLAT_SHIFT(XLAT_SHIFT)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bank_wr),
        .dec  (dec),
        .wdata(wide_wdata),
        .rdata(bank_rdata)
    );

    csb_ctrl_reg #(
        .CTRL_MASK(CTRL_MASK)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(ctrl_wr),
        .wdata(wide_wdata),
        .rdata(ctrl_rdata)
    );

    always_comb begin
        case (dec.kind)
            SEL_CTRL:                    sel_rdata = ctrl_rdata;
            SEL_BASE, SEL_MASK, SEL_XLAT: sel_rdata = bank_rdata;
            default:                     sel_rdata = '0;
        endcase
    end

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.cmt_valid = 1'b0;
        if (wr_lo) d.latch = req_wdata;
        if (wr_hi) begin
            d.cmt_valid = 1'b1;
            d.cmt_addr  = {req_addr[ADDR_W-1:3], 3'b000};
            d.cmt_data  = wide_wdata;
        end
        if (rd_lo) begin
            d.rsp_valid = 1'b1;
            d.rsp_data  = sel_rdata[31:0];
            d.latch     = sel_rdata[63:32];
        end
        if (rd_hi) begin
            d.rsp_valid = 1'b1;
            d.rsp_data  = q.latch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid    = q.rsp_valid;
    assign rsp_rdata    = q.rsp_data;
    assign commit_valid = q.cmt_valid;
    assign commit_addr  = q.cmt_addr;
    assign commit_data  = q.cmt_data;

endmodule

// File: rtl/csb_split_bridge_chk.sv
module csb_split_bridge_chk #(
    parameter int          ADDR_W    = 12,
    parameter logic [63:0] CTRL_MASK = 64'h0000_001C_FF0F_C7FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              commit_valid,
    input logic [ADDR_W-1:0] commit_addr,
    input logic [63:0]       commit_data,
    input logic [31:0]       latch_q,
    input logic [63:0]       ctrl_q
);
    logic wr_lo, wr_hi, rd_any, rd_hi;
    assign wr_lo  = req_valid &&  req_write && !req_addr[2];
    assign wr_hi  = req_valid &&  req_write &&  req_addr[2];
    assign rd_any = req_valid && !req_write;
    assign rd_hi  = req_valid && !req_write &&  req_addr[2];

    assert_half_write_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !commit_valid);

    assert_commit_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (commit_valid
                   && commit_data == {$past(req_wdata), $past(latch_q)}
                   && commit_addr == {$past(req_addr[ADDR_W-1:3]), 3'b000}));

    assert_commit_only_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> !commit_valid);

    assert_upper_read_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (latch_q == $past(latch_q) && rsp_rdata == $past(latch_q)));

    assert_ctrl_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((ctrl_q & ~CTRL_MASK) == ($past(ctrl_q) & ~CTRL_MASK)));

    assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> rsp_valid);

    assert_no_rsp_otherwise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !rsp_valid);

endmodule

bind csb_split_bridge csb_split_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_MASK(CTRL_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .commit_valid(commit_valid),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .latch_q     (q.latch),
    .ctrl_q      (ctrl_rdata)
);

// File: tb/sim_csb_split_bridge.sv
module sim_csb_split_bridge;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 12;
    localparam logic [63:0] CMASK      = 64'h0000_001C_FF0F_C7FF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              commit_valid;
    logic [ADDR_W-1:0] commit_addr;
    logic [63:0]       commit_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csb_split_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .commit_valid(commit_valid), .commit_addr(commit_addr),
        .commit_data(commit_data)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One request held for one clock; outputs sampled on the next falling edge.
    task automatic access(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] dat);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = dat;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic write64(input logic [ADDR_W-1:0] a, input logic [63:0] v);
        access(1'b1, a, v[31:0]);
        access(1'b1, a | 12'h004, v[63:32]);
    endtask

    task automatic read64(input logic [ADDR_W-1:0] a, output logic [63:0] v);
        access(1'b0, a, 32'h0);
        v[31:0] = rsp_rdata;
        access(1'b0, a | 12'h004, 32'h0);
        v[63:32] = rsp_rdata;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        check("R9 rsp_valid", 64'(rsp_valid), 64'h0);
        check("R9 rsp_rdata", 64'(rsp_rdata), 64'h0);
        check("R9 commit_valid", 64'(commit_valid), 64'h0);
        check("R9 commit_data", commit_data, 64'h0);
        read64(12'h2C0, v);
        check("R9 xlat3 reset", v, 64'h0);
        read64(12'h300, v);
        check("R9 ctrl reset", v, 64'h0);
    endtask

    task automatic t_lower_write;
        logic [63:0] v;
        access(1'b1, 12'h000, 32'hDEAD_BEEF);
        check("R1 no commit", 64'(commit_valid), 64'h0);
        check("R10 no rsp on write", 64'(rsp_valid), 64'h0);
        read64(12'h000, v);
        check("R1 base0 unchanged", v, 64'h0);
    endtask

    task automatic t_commit_base;
        logic [63:0] v;
        access(1'b1, 12'h040, 32'hAABB_CCDD);
        access(1'b1, 12'h044, 32'h1122_3344);
        check("R2 commit_valid", 64'(commit_valid), 64'h1);
        check("R2 commit_addr", 64'(commit_addr), 64'h040);
        check("R2 commit_data", commit_data, 64'h1122_3344_AABB_CCDD);
        @(negedge clk);
        check("R2 pulse one cycle", 64'(commit_valid), 64'h0);
        access(1'b0, 12'h040, 32'h0);
        check("R10 rsp_valid", 64'(rsp_valid), 64'h1);
        check("R3 base1 low", 64'(rsp_rdata), 64'hAABB_CCDD);
        access(1'b0, 12'h044, 32'h0);
        check("R5 base1 high zero", 64'(rsp_rdata), 64'h0);
        read64(12'h000, v);
        check("R5 base0 untouched", v, 64'h0);
    endtask

    task automatic t_mask;
        logic [63:0] v;
        write64(12'h1C0, 64'h7777_0000_FFF0_0000);
        check("R2 mask3 commit_addr", 64'(commit_addr), 64'h1C0);
        read64(12'h1C0, v);
        check("R5 mask3 readback", v, 64'h0000_0000_FFF0_0000);
        read64(12'h040, v);
        check("R5 base1 kept", v, 64'h0000_0000_AABB_CCDD);
    endtask

    task automatic t_xlat;
        logic [63:0] v, src, e;
        src = 64'h0000_0123_4567_89AB;
        write64(12'h280, src);
        e = ((src >> 10) & 64'hFFFF_FFFF) << 10;
        read64(12'h280, v);
        check("R6 xlat2 readback", v, e);
        src = 64'hFFFF_FFFF_FFFF_FFFF;
        write64(12'h200, src);
        e = ((src >> 10) & 64'hFFFF_FFFF) << 10;
        read64(12'h200, v);
        check("R6 xlat0 all ones", v, e);
    endtask

    task automatic t_ctrl;
        logic [63:0] v;
        write64(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
        read64(12'h300, v);
        check("R7 ctrl ones", v, CMASK);
        write64(12'h300, 64'h0000_0008_0000_0001);
        read64(12'h300, v);
        check("R7 ctrl pattern", v, 64'h0000_0008_0000_0001);
    endtask

    task automatic t_unlisted;
        logic [63:0] v;
        write64(12'h340, 64'hCAFE_F00D_1234_5678);
        read64(12'h340, v);
        check("R8 unlisted reads zero", v, 64'h0);
        write64(12'h048, 64'h5555_5555_5555_5555);
        read64(12'h040, v);
        check("R8 gap write ignored", v, 64'h0000_0000_AABB_CCDD);
    endtask

    task automatic t_shared_latch;
        logic [63:0] v;
        write64(12'h300, CMASK);
        access(1'b0, 12'h300, 32'h0);
        check("R3 ctrl low", 64'(rsp_rdata), 64'hFF0F_C7FF);
        access(1'b0, 12'h0C4, 32'h0);
        check("R4 upper read returns latch", 64'(rsp_rdata), 64'h1C);
        access(1'b0, 12'h0C4, 32'h0);
        check("R4 latch unchanged", 64'(rsp_rdata), 64'h1C);
        access(1'b1, 12'h0C4, 32'h0000_0007);
        check("R11 commit uses read latch", commit_data, 64'h0000_0007_0000_001C);
        read64(12'h0C0, v);
        check("R11 base3 value", v, 64'h0000_0000_0000_001C);
        read64(12'h300, v);
        check("R4 ctrl untouched by reads", v, CMASK);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lower_write();
        t_commit_base();
        t_mask();
        t_xlat();
        t_ctrl();
        t_unlisted();
        t_shared_latch();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule